// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block sits beside a small 8-bit CPU and turns six peripheral event sources into vectored calls: an external interrupt pin, timer 0, timer 1, a UART, an I2C port and one shared source that merges three timing events. Each source has a request flag that is latched from its events. A flag stays set until the CPU takes its vector. Per-source enables, a global enable and a stack-full input decide whether a pending flag may be serviced.

Arbitration happens only when the CPU pulses the sampling strobe. Any requests that arrived since the previous strobe are then judged together, and the one with the lowest vector address wins. The controller is built around a two-state machine. `ST_IDLE` waits for a strobe while at least one request is eligible, then moves through the transition `GRANT` into `ST_TAKE`. `ST_TAKE` lasts one cycle. In that cycle the take strobe and the vector address are driven. At its end the transition `RETIRE` clears the winning flag and the global enable and returns to `ST_IDLE`. The CPU re-enables interrupts with its return-from-interrupt strobe. A plain return strobe leaves the global enable alone.

The shared timing source keeps three sticky sub-flags. Software clears each of them explicitly. Taking the vector clears only the merged request flag.

Top module: `vic_core`

## Requirements
- R1: The vector address is a function of the source index i, where bit i of `src_en_i` and `req_flags_o` belongs to that source: 0 external pin gives 0x04, 1 timer 0 gives 0x08, 2 timer 1 gives 0x0C, 3 UART gives 0x10, 4 I2C gives 0x14, 5 shared timing source gives 0x18. Outside a take, `vector_o` is 0.
- R2: Request flag 0 is set by a high-to-low transition of `int_pin_i`. A steady level or a low-to-high transition does not set it.
- R3: A take happens only if all of these hold at a strobe: `gie_o` is 1, the source enable bit is 1, the request flag is set and `stack_full_i` is 0. `take_o` is then high for exactly one cycle, the cycle after the strobe.
- R4: At the end of the take cycle, the winning source's request flag is cleared and `gie_o` is cleared.
- R5: A pulse on `reti_i` sets `gie_o`. A pulse on `ret_i` leaves `gie_o` unchanged.
- R6: Request flag 5 is set by any of `tmr2_ovf_i`, `rtc_tmo_i` or `tbase_tmo_i`. Each of these also sets a sticky sub-flag in `mf_sub_o`, at bit 0, 1 and 2 respectively. A take does not clear the sub-flags. Only a 1 in the matching bit of `mf_sub_clr_i` clears one.
- R7: Request flag 3 is set by any of the four UART conditions: transmit enable, receive done, transmit idle or receive idle.
- R8: Request flag 4 is set by an I2C address match or by a completed byte.
- R9: Flags collect between strobes without causing a take. At a strobe, exactly one of the eligible requests is serviced. The others stay pending for a later strobe.
- R10: When several requests are eligible at once, the lowest vector address wins.
- R11: If a setting event for a flag coincides with the clear caused by a take, the flag ends set.
- R12: After reset, all request flags, sub-flags, `gie_o`, `take_o` and `vector_o` are 0.
- R13: A pulse on `gie_wr_i` loads `gie_wdata_i` into the global enable, unless a take or `reti_i` acts in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_i | input | 1 | Sampling strobe from the CPU |
| int_pin_i | input | 1 | External interrupt pin, falling-edge sensitive |
| tmr0_ovf_i | input | 1 | Timer 0 overflow pulse |
| tmr1_ovf_i | input | 1 | Timer 1 overflow pulse |
| uart_tx_en_i | input | 1 | UART transmit-enable event |
| uart_rx_done_i | input | 1 | UART byte received |
| uart_tx_idle_i | input | 1 | UART transmitter idle |
| uart_rx_idle_i | input | 1 | UART receiver idle |
| i2c_addr_hit_i | input | 1 | I2C slave address matched |
| i2c_byte_done_i | input | 1 | I2C byte transfer finished |
| tmr2_ovf_i | input | 1 | Timer 2 overflow pulse (shared source) |
| rtc_tmo_i | input | 1 | Real-time-clock time-out pulse (shared source) |
| tbase_tmo_i | input | 1 | Time-base time-out pulse (shared source) |
| mf_sub_clr_i | input | 3 | Software clear of the shared-source sub-flags |
| src_en_i | input | 6 | Per-source enables |
| gie_wr_i | input | 1 | Software write strobe for the global enable |
| gie_wdata_i | input | 1 | Value written to the global enable |
| ret_i | input | 1 | Plain return strobe |
| reti_i | input | 1 | Return-from-interrupt strobe |
| stack_full_i | input | 1 | Call stack is full |
| take_o | output | 1 | Vector taken this cycle |
| vector_o | output | 8 | Vector address |
| gie_o | output | 1 | Global interrupt enable |
| req_flags_o | output | 6 | Request flags, bit per source index |
| mf_sub_o | output | 3 | Sticky sub-flags of the shared source |

## Verification
Some rules are checked on every cycle: a take lasts exactly one cycle, it follows a strobe taken with the global enable set and the stack not full, it clears the global enable, and its vector lies on the legal grid. The effect of `reti_i` and `ret_i` on the enable and the persistence of the sub-flags are also checked every cycle. Other behaviour can only be shown by the bench's scenarios. This covers which source wins among several, requests piling up over many strobe-free cycles, an edge of the interrupt pin landing in the same cycle as its flag clear, and each UART and I2C condition setting its flag on its own.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int NSRC  = 6;
    localparam int NMF   = 3;
    localparam int IDX_W = $clog2(NSRC);
    localparam int VEC_W = 8;

    // source indices, ordered by vector address
    localparam int SRC_EXT  = 0;
    localparam int SRC_TMR0 = 1;
    localparam int SRC_TMR1 = 2;
    localparam int SRC_UART = 3;
    localparam int SRC_I2C  = 4;
    localparam int SRC_MF   = 5;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_TAKE = 1'b1
    } vic_state_e;
endpackage

// File: rtl/vic_fall_detect.sv
module vic_fall_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic fall_o
);
    logic prev_q;

    // previous level resets high so a pin held high is quiet after reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= pin_i;
    end

    assign fall_o = prev_q & ~pin_i;
endmodule

// File: rtl/vic_flag_bank.sv
module vic_flag_bank #(
    parameter int N_REQ = 6,
    parameter int N_SUB = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_REQ-1:0] req_set_i,
    input  logic [N_REQ-1:0] req_clr_i,
    input  logic [N_SUB-1:0] sub_set_i,
    input  logic [N_SUB-1:0] sub_clr_i,
    output logic [N_REQ-1:0] req_o,
    output logic [N_SUB-1:0] sub_o
);
    logic [N_REQ-1:0] req_q;
    logic [N_SUB-1:0] sub_q;

    // a set in the same cycle as a clear wins, so no event is dropped
    for (genvar g = 0; g < N_REQ; g++) begin : g_req
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) req_q[g] <= 1'b0;
            else        req_q[g] <= req_set_i[g] | (req_q[g] & ~req_clr_i[g]);
        end
    end

    for (genvar s = 0; s < N_SUB; s++) begin : g_sub
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sub_q[s] <= 1'b0;
            else        sub_q[s] <= sub_set_i[s] | (sub_q[s] & ~sub_clr_i[s]);
        end
    end

    assign req_o = req_q;
    assign sub_o = sub_q;
endmodule

// File: rtl/vic_prio_pick.sv
module vic_prio_pick #(
    parameter int N     = 6,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    // scan from the top down so the lowest index is left standing
    always_comb begin
        any_o = |req_i;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IDX_W'(i);
        end
    end
endmodule

// File: rtl/vic_core.sv
module vic_core
    import vic_pkg::*;
#(
    parameter int VEC_BASE = 4,
    parameter int VEC_STEP = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_i,
    input  logic             int_pin_i,
    input  logic             tmr0_ovf_i,
    input  logic             tmr1_ovf_i,
    input  logic             uart_tx_en_i,
    input  logic             uart_rx_done_i,
    input  logic             uart_tx_idle_i,
    input  logic             uart_rx_idle_i,
    input  logic             i2c_addr_hit_i,
    input  logic             i2c_byte_done_i,
    input  logic             tmr2_ovf_i,
    input  logic             rtc_tmo_i,
    input  logic             tbase_tmo_i,
    input  logic [NMF-1:0]   mf_sub_clr_i,
    input  logic [NSRC-1:0]  src_en_i,
    input  logic             gie_wr_i,
    input  logic             gie_wdata_i,
    input  logic             ret_i,
    input  logic             reti_i,
    input  logic             stack_full_i,
    output logic             take_o,
    output logic [VEC_W-1:0] vector_o,
    output logic             gie_o,
    output logic [NSRC-1:0]  req_flags_o,
    output logic [NMF-1:0]   mf_sub_o
);
    vic_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             gie_q;
    logic             ext_fall;
    logic [NSRC-1:0]  req_set, req_clr, req_q, eligible;
    logic [NMF-1:0]   mf_set, mf_q;
    logic             pick_any;
    logic [IDX_W-1:0] pick_idx;

    vic_fall_detect u_fall (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (int_pin_i),
        .fall_o (ext_fall)
    );

    assign mf_set = {tbase_tmo_i, rtc_tmo_i, tmr2_ovf_i};

    always_comb begin
        req_set           = '0;
        req_set[SRC_EXT]  = ext_fall;
        req_set[SRC_TMR0] = tmr0_ovf_i;
        req_set[SRC_TMR1] = tmr1_ovf_i;
        req_set[SRC_UART] = uart_tx_en_i | uart_rx_done_i | uart_tx_idle_i | uart_rx_idle_i;
        req_set[SRC_I2C]  = i2c_addr_hit_i | i2c_byte_done_i;
        req_set[SRC_MF]   = |mf_set;
    end

    vic_flag_bank #(
        .N_REQ (NSRC),
        .N_SUB (NMF)
    ) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_set_i (req_set),
        .req_clr_i (req_clr),
        .sub_set_i (mf_set),
        .sub_clr_i (mf_sub_clr_i),
        .req_o     (req_q),
        .sub_o     (mf_q)
    );

    assign eligible = req_q & src_en_i & {NSRC{gie_q & ~stack_full_i}};

    vic_prio_pick #(
        .N     (NSRC),
        .IDX_W (IDX_W)
    ) u_pick (
        .req_i (eligible),
        .any_o (pick_any),
        .idx_o (pick_idx)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // transitions: GRANT (idle -> take), RETIRE (take -> idle)
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (sample_i && pick_any) begin
                    state_d = ST_TAKE;
                    idx_d   = pick_idx;
                end
            end
            ST_TAKE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        take_o   = 1'b0;
        vector_o = '0;
        req_clr  = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_TAKE: begin
                take_o        = 1'b1;
                vector_o      = VEC_W'(VEC_BASE) + VEC_W'(idx_q) * VEC_W'(VEC_STEP);
                req_clr[idx_q] = 1'b1;
            end
            default: ;
        endcase
    end

    // global enable: a take wins, then return-from-interrupt, then software
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        gie_q <= 1'b0;
        else if (take_o)   gie_q <= 1'b0;
        else if (reti_i)   gie_q <= 1'b1;
        else if (gie_wr_i) gie_q <= gie_wdata_i;
        else if (ret_i)    gie_q <= gie_q;
    end

    assign gie_o       = gie_q;
    assign req_flags_o = req_q;
    assign mf_sub_o    = mf_q;
endmodule

// File: rtl/vic_core_chk.sv
module vic_core_chk
    import vic_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             sample_i,
    input logic             tmr0_ovf_i,
    input logic [NMF-1:0]   mf_sub_clr_i,
    input logic             gie_wr_i,
    input logic             ret_i,
    input logic             reti_i,
    input logic             stack_full_i,
    input logic             take_o,
    input logic [VEC_W-1:0] vector_o,
    input logic             gie_o,
    input logic [NSRC-1:0]  req_flags_o,
    input logic [NMF-1:0]   mf_sub_o
);
    AST_VEC_ON_GRID: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (vector_o[1:0] == 2'b00 && vector_o >= 8'h04 && vector_o <= 8'h18)); // R1

    AST_TAKE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> $past(sample_i)); // R3

    AST_TAKE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> $past(gie_o && !stack_full_i)); // R3

    AST_TAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o); // R3

    AST_GIE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !gie_o); // R4

    AST_TMR0_FLAG_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && vector_o == 8'h08 && !tmr0_ovf_i) |=> !req_flags_o[1]); // R4

    AST_RETI_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (reti_i && !take_o) |=> gie_o); // R5

    AST_RET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && !reti_i && !gie_wr_i && !take_o) |=> (gie_o == $past(gie_o))); // R5

    AST_SUB_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((mf_sub_o & $past(mf_sub_o & ~mf_sub_clr_i)) == $past(mf_sub_o & ~mf_sub_clr_i))); // R6

    AST_TAKE_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> ($past(req_flags_o) != '0)); // R9
endmodule

bind vic_core vic_core_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_i     (sample_i),
    .tmr0_ovf_i   (tmr0_ovf_i),
    .mf_sub_clr_i (mf_sub_clr_i),
    .gie_wr_i     (gie_wr_i),
    .ret_i        (ret_i),
    .reti_i       (reti_i),
    .stack_full_i (stack_full_i),
    .take_o       (take_o),
    .vector_o     (vector_o),
    .gie_o        (gie_o),
    .req_flags_o  (req_flags_o),
    .mf_sub_o     (mf_sub_o)
);

// File: tb/vic_core_tb.sv
module vic_core_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NTBL = 8;

    // {fire[5:0], en[5:0], full, exp_take, exp_vec[7:0]}
    localparam logic [21:0] TBL [NTBL] = '{
        {6'b000001, 6'b111111, 1'b0, 1'b1, 8'h04},
        {6'b111110, 6'b111111, 1'b0, 1'b1, 8'h08},
        {6'b110000, 6'b111111, 1'b0, 1'b1, 8'h14},
        {6'b100000, 6'b111111, 1'b0, 1'b1, 8'h18},
        {6'b101000, 6'b011111, 1'b0, 1'b1, 8'h10},
        {6'b000110, 6'b111111, 1'b1, 1'b0, 8'h00},
        {6'b000000, 6'b111111, 1'b0, 1'b0, 8'h00},
        {6'b001000, 6'b000000, 1'b0, 1'b0, 8'h00}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sample_i = 0, int_pin_i = 1, tmr0_ovf_i = 0, tmr1_ovf_i = 0;
    logic uart_tx_en_i = 0, uart_rx_done_i = 0, uart_tx_idle_i = 0, uart_rx_idle_i = 0;
    logic i2c_addr_hit_i = 0, i2c_byte_done_i = 0;
    logic tmr2_ovf_i = 0, rtc_tmo_i = 0, tbase_tmo_i = 0;
    logic [2:0] mf_sub_clr_i = '0;
    logic [5:0] src_en_i = '0;
    logic gie_wr_i = 0, gie_wdata_i = 0, ret_i = 0, reti_i = 0, stack_full_i = 0;
    logic       take_o, gie_o;
    logic [7:0] vector_o;
    logic [5:0] req_flags_o;
    logic [2:0] mf_sub_o;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    vic_core u_dut (
        .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .int_pin_i(int_pin_i),
        .tmr0_ovf_i(tmr0_ovf_i), .tmr1_ovf_i(tmr1_ovf_i),
        .uart_tx_en_i(uart_tx_en_i), .uart_rx_done_i(uart_rx_done_i),
        .uart_tx_idle_i(uart_tx_idle_i), .uart_rx_idle_i(uart_rx_idle_i),
        .i2c_addr_hit_i(i2c_addr_hit_i), .i2c_byte_done_i(i2c_byte_done_i),
        .tmr2_ovf_i(tmr2_ovf_i), .rtc_tmo_i(rtc_tmo_i), .tbase_tmo_i(tbase_tmo_i),
        .mf_sub_clr_i(mf_sub_clr_i), .src_en_i(src_en_i),
        .gie_wr_i(gie_wr_i), .gie_wdata_i(gie_wdata_i), .ret_i(ret_i), .reti_i(reti_i),
        .stack_full_i(stack_full_i), .take_o(take_o), .vector_o(vector_o),
        .gie_o(gie_o), .req_flags_o(req_flags_o), .mf_sub_o(mf_sub_o)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        int_pin_i = 1'b1;
        src_en_i = '0;
        stack_full_i = 1'b0;
        repeat (2) tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic set_gie();
        gie_wr_i = 1'b1; gie_wdata_i = 1'b1;
        tick();
        gie_wr_i = 1'b0; gie_wdata_i = 1'b0;
    endtask

    task automatic strobe();
        sample_i = 1'b1;
        tick();
        sample_i = 1'b0;
    endtask

    task automatic fire(input int i);
        case (i)
            0: begin int_pin_i = 1'b0; tick(); int_pin_i = 1'b1; tick(); end
            1: begin tmr0_ovf_i = 1'b1; tick(); tmr0_ovf_i = 1'b0; end
            2: begin tmr1_ovf_i = 1'b1; tick(); tmr1_ovf_i = 1'b0; end
            3: begin uart_rx_done_i = 1'b1; tick(); uart_rx_done_i = 1'b0; end
            4: begin i2c_byte_done_i = 1'b1; tick(); i2c_byte_done_i = 1'b0; end
            default: begin tmr2_ovf_i = 1'b1; tick(); tmr2_ovf_i = 1'b0; end
        endcase
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // R12: reset state
        repeat (2) tick();
        chk("R12 flags", {26'd0, req_flags_o}, 32'd0);
        chk("R12 subs", {29'd0, mf_sub_o}, 32'd0);
        chk("R12 gie/take", {30'd0, gie_o, take_o}, 32'd0);
        chk("R12 vector", {24'd0, vector_o}, 32'd0);

        // table walk: R1 R3 R10 R13
        for (int t = 0; t < NTBL; t++) begin
            do_reset();
            set_gie();
            chk("R13 gie write", {31'd0, gie_o}, 32'd1);
            src_en_i = TBL[t][15:10];
            for (int b = 0; b < 6; b++) if (TBL[t][16 + b]) fire(b);
            stack_full_i = TBL[t][9];
            strobe();
            chk($sformatf("R1/R3/R10 take row %0d", t), {31'd0, take_o}, {31'd0, TBL[t][8]});
            chk($sformatf("R1/R10 vector row %0d", t), {24'd0, vector_o}, {24'd0, TBL[t][7:0]});
            stack_full_i = 1'b0;
            tick();
        end

        // R2 and R4 and R5: falling edge only; take clears; RET/RETI
        do_reset();
        repeat (3) tick();
        chk("R2 steady high", {31'd0, req_flags_o[0]}, 32'd0);
        int_pin_i = 1'b0;
        tick();
        chk("R2 falling edge", {31'd0, req_flags_o[0]}, 32'd1);
        src_en_i = 6'b000001;
        set_gie();
        strobe();
        chk("R1 ext vector", {24'd0, vector_o}, 32'h04);
        tick();
        chk("R4 flag cleared", {31'd0, req_flags_o[0]}, 32'd0);
        chk("R4 gie cleared", {31'd0, gie_o}, 32'd0);
        tick();
        chk("R2 held low", {31'd0, req_flags_o[0]}, 32'd0);
        int_pin_i = 1'b1;
        tick();
        chk("R2 rising edge", {31'd0, req_flags_o[0]}, 32'd0);
        ret_i = 1'b1; tick(); ret_i = 1'b0;
        chk("R5 ret keeps gie", {31'd0, gie_o}, 32'd0);
        reti_i = 1'b1; tick(); reti_i = 1'b0;
        chk("R5 reti sets gie", {31'd0, gie_o}, 32'd1);
        ret_i = 1'b1; tick(); ret_i = 1'b0;
        chk("R5 ret keeps gie set", {31'd0, gie_o}, 32'd1);

        // R7: each UART condition
        for (int u = 0; u < 4; u++) begin
            do_reset();
            case (u)
                0: uart_tx_en_i = 1'b1;
                1: uart_rx_done_i = 1'b1;
                2: uart_tx_idle_i = 1'b1;
                default: uart_rx_idle_i = 1'b1;
            endcase
            tick();
            {uart_tx_en_i, uart_rx_done_i, uart_tx_idle_i, uart_rx_idle_i} = '0;
            chk($sformatf("R7 uart cond %0d", u), {26'd0, req_flags_o}, 32'h08);
        end

        // R8: each I2C condition
        for (int c = 0; c < 2; c++) begin
            do_reset();
            if (c == 0) i2c_addr_hit_i = 1'b1; else i2c_byte_done_i = 1'b1;
            tick();
            i2c_addr_hit_i = 1'b0; i2c_byte_done_i = 1'b0;
            chk($sformatf("R8 i2c cond %0d", c), {26'd0, req_flags_o}, 32'h10);
        end

        // R6: shared source and sticky sub-flags
        do_reset();
        rtc_tmo_i = 1'b1; tick(); rtc_tmo_i = 1'b0;
        chk("R6 rtc sets flag", {26'd0, req_flags_o}, 32'h20);
        chk("R6 rtc sub", {29'd0, mf_sub_o}, 32'h2);
        src_en_i = 6'b100000;
        set_gie();
        strobe();
        chk("R6 mf vector", {24'd0, vector_o}, 32'h18);
        tick();
        chk("R6 mf flag cleared", {31'd0, req_flags_o[5]}, 32'd0);
        chk("R6 sub survives take", {29'd0, mf_sub_o}, 32'h2);
        mf_sub_clr_i = 3'b010; tick(); mf_sub_clr_i = '0;
        chk("R6 sub cleared", {29'd0, mf_sub_o}, 32'h0);
        tbase_tmo_i = 1'b1; tick(); tbase_tmo_i = 1'b0;
        chk("R6 tbase sub", {29'd0, mf_sub_o}, 32'h4);
        chk("R6 tbase flag", {31'd0, req_flags_o[5]}, 32'd1);

        // R3: global enable low blocks
        do_reset();
        src_en_i = 6'b111111;
        fire(1);
        strobe();
        chk("R3 gie low no take", {31'd0, take_o}, 32'd0);

        // R9 and R10: accumulate, serve one per strobe
        do_reset();
        src_en_i = 6'b111111;
        set_gie();
        fire(3);
        fire(2);
        begin
            int seen = 0;
            for (int k = 0; k < 6; k++) begin tick(); if (take_o) seen++; end
            chk("R9 no take without strobe", seen, 0);
        end
        strobe();
        chk("R10 timer1 first", {24'd0, vector_o}, 32'h0C);
        tick();
        chk("R9 uart still pending", {26'd0, req_flags_o}, 32'h08);
        reti_i = 1'b1; tick(); reti_i = 1'b0;
        strobe();
        chk("R9 uart at later strobe", {24'd0, vector_o}, 32'h10);
        tick();

        // R11: pin edge coincides with clear
        do_reset();
        src_en_i = 6'b000001;
        set_gie();
        fire(0);
        strobe();
        chk("R11 take ext", {24'd0, vector_o}, 32'h04);
        int_pin_i = 1'b0;
        tick();
        chk("R11 flag re-set", {31'd0, req_flags_o[0]}, 32'd1);
        chk("R4 gie cleared again", {31'd0, gie_o}, 32'd0);
        int_pin_i = 1'b1;
        tick();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule